// File: doc/BRIEF.md
# Display Link Seven-to-One Serializer

This block turns a parallel pixel word of 21 bits into three serial data lanes plus a forwarded clock lane. The word holds 18 colour bits and three timing bits: line sync, frame sync and data enable. It is captured once per pixel clock period. Each lane then sends seven of the captured bits, one per bit-clock period. An outside source supplies both the pixel clock and a bit clock running at seven times its rate.

A static strap input chooses which pixel-clock edge captures the word. A high level selects the rising edge. Any other level selects the falling edge, so a strap left pulled low gives falling-edge capture. The block finds each pixel period boundary by watching the pixel clock from the bit-clock domain. On the second bit-clock rising edge after a pixel-clock rising edge, it moves the most recently captured word into the lane shift registers. The clock lane repeats a fixed seven-slot pattern from that same boundary, so a receiver can find where each word starts.

An active-low power-down input blanks every lane and drops the shared output enable, which stands for a high-impedance driver. After power-down is released, the enable returns only at the next word boundary, so a partial word is never sent.

Top module: `dispLinkSer`

## Requirements
- R1: Input bit positions: pixWord[5:0] is red, [11:6] is green, [17:12] is blue, [18] is line sync, [19] is frame sync and [20] is data enable.
- R2: Data lane L sends pixWord bits 7L to 7L+6 in slots 0 to 6. Slot 0 goes first, and the slots take consecutive bit-clock periods.
- R3: With strobeSel high, the word is captured on the rising pixel-clock edge.
- R4: With strobeSel low, the word is captured on the falling pixel-clock edge.
- R5: In every pixel period, the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6.
- R6: Slot 0 of a word is driven from the second bit-clock rising edge after the pixel-clock rising edge that begins the period. That word is the last one captured before that edge.
- R7: From the first bit-clock edge at which pdN is sampled low, laneOe is 0 and all data lanes and the clock lane are 0.
- R8: After pdN returns high, laneOe stays 0 until the next word boundary. It then rises together with slot 0 of a complete word.
- R9: During and after reset, until the first word boundary, laneOe is 0 and all lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock, seven times the pixel clock |
| pixClk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Active-low power-down |
| strobeSel | input | 1 | Capture edge strap: 1 selects rising, otherwise falling |
| pixWord | input | 21 | Parallel pixel word (colour and timing bits) |
| laneData | output | 3 | Serial data lanes, one bit per lane |
| clkLane | output | 1 | Forwarded clock-lane pattern |
| laneOe | output | 1 | Lane output enable (0 means high impedance) |

## Verification
The assertions rely on two assumptions about the clocks. Each pixel period lasts exactly seven bit-clock periods, and no pixel-clock edge coincides with a bit-clock rising edge. Under these assumptions, a word boundary can only come when the slot counter has finished a full period or is still unsynchronised after reset. The bench builds both clocks from fixed delays with a 2 ns offset, so every edge is separate. It changes pixWord, pdN and strobeSel only midway between edges. The strap is changed only between words.

// File: rtl/dlser_pkg.sv
package dlser_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;      // word boundary: move captured word into the shifters
    logic pdActive;  // power-down is being applied
  } serCtl_t;
endpackage

// File: rtl/serCtl.sv
module serCtl
  import dlser_pkg::*;
#(
  parameter int SLOTS = 7
) (
  input  logic    bitClk,
  input  logic    rstN,
  input  logic    pdN,
  input  logic    pixClk,
  output serCtl_t ctl,
  output logic    laneOe
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] UNSYNCED  = CNT_W'(SLOTS);

  logic pixQ, pixQd;
  logic boundary;
  logic [CNT_W-1:0] slotCnt;

  // Pixel clock seen from the bit-clock domain
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      pixQ  <= 1'b0;
      pixQd <= 1'b0;
    end else begin
      pixQ  <= pixClk;
      pixQd <= pixQ;
    end
  end

  assign boundary     = pixQ & ~pixQd;
  assign ctl.load     = boundary;
  assign ctl.pdActive = ~pdN;

  // Slot position within the pixel period; UNSYNCED until the first boundary
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)                    slotCnt <= UNSYNCED;
    else if (boundary)            slotCnt <= '0;
    else if (slotCnt < LAST_SLOT) slotCnt <= slotCnt + 1'b1;
  end

  // Output enable: off in power-down, back on only at a full-word boundary
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)         laneOe <= 1'b0;
    else if (!pdN)     laneOe <= 1'b0;
    else if (boundary) laneOe <= 1'b1;
  end

  // R6: boundaries come only after a full period of slots (or before sync)
  p_boundary_spacing_r6: assert property (@(posedge bitClk) disable iff (!rstN)
    boundary |-> (slotCnt == LAST_SLOT || slotCnt == UNSYNCED));

  // R7: power-down removes the enable on the next edge
  p_pd_disables_oe_r7: assert property (@(posedge bitClk) disable iff (!rstN)
    !pdN |=> !laneOe);

  // R8: the enable only comes back at a word boundary
  p_oe_at_boundary_r8: assert property (@(posedge bitClk) disable iff (!rstN)
    $rose(laneOe) |-> $past(ctl.load));
endmodule

// File: rtl/serData.sv
module serData
  import dlser_pkg::*;
#(
  parameter int               LANES       = 3,
  parameter int               SLOTS       = 7,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                   bitClk,
  input  logic                   pixClk,
  input  logic                   rstN,
  input  logic                   strobeSel,
  input  logic [LANES*SLOTS-1:0] pixWord,
  input  serCtl_t                ctl,
  input  logic                   laneOe,
  output logic [LANES-1:0]       laneData,
  output logic                   clkLane
);
  localparam int WORD_W = LANES * SLOTS;

  logic [WORD_W-1:0] capRise, capFall, selWord;
  logic [SLOTS-1:0]  clkSh;

  // Two capture registers; the strap picks one
  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) capRise <= '0;
    else       capRise <= pixWord;
  end

  always_ff @(negedge pixClk or negedge rstN) begin
    if (!rstN) capFall <= '0;
    else       capFall <= pixWord;
  end

  always_comb begin
    if (strobeSel == 1'b1) selWord = capRise;
    else                   selWord = capFall;
  end

  // One shifter per data lane, slot 0 at bit 0 and sent first
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] sh;
    always_ff @(posedge bitClk or negedge rstN) begin
      if (!rstN)             sh <= '0;
      else if (ctl.pdActive) sh <= '0;
      else if (ctl.load)     sh <= selWord[l*SLOTS +: SLOTS];
      else                   sh <= sh >> 1;
    end
    assign laneData[l] = laneOe & sh[0];
  end

  // Clock-lane pattern shifter
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)             clkSh <= '0;
    else if (ctl.pdActive) clkSh <= '0;
    else if (ctl.load)     clkSh <= CLK_PATTERN;
    else                   clkSh <= clkSh >> 1;
  end
  assign clkLane = laneOe & clkSh[0];

  // R7: lanes go quiet after power-down is sampled
  p_lanes_quiet_r7: assert property (@(posedge bitClk) disable iff (!rstN)
    ctl.pdActive |=> (laneData == '0 && !clkLane));

  // R5: the clock lane starts each period with the pattern's slot 0
  p_clk_slot0_r5: assert property (@(posedge bitClk) disable iff (!rstN)
    (ctl.load && !ctl.pdActive) |=> (clkLane == CLK_PATTERN[0]));
endmodule

// File: rtl/dispLinkSer.sv
module dispLinkSer
  import dlser_pkg::*;
#(
  parameter int               LANES       = 3,
  parameter int               SLOTS       = 7,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                   bitClk,
  input  logic                   pixClk,
  input  logic                   rstN,
  input  logic                   pdN,
  input  logic                   strobeSel,
  input  logic [LANES*SLOTS-1:0] pixWord,
  output logic [LANES-1:0]       laneData,
  output logic                   clkLane,
  output logic                   laneOe
);
  serCtl_t ctl;

  serCtl #(.SLOTS(SLOTS)) u_ctl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .pdN    (pdN),
    .pixClk (pixClk),
    .ctl    (ctl),
    .laneOe (laneOe)
  );

  serData #(.LANES(LANES), .SLOTS(SLOTS), .CLK_PATTERN(CLK_PATTERN)) u_data (
    .bitClk    (bitClk),
    .pixClk    (pixClk),
    .rstN      (rstN),
    .strobeSel (strobeSel),
    .pixWord   (pixWord),
    .ctl       (ctl),
    .laneOe    (laneOe),
    .laneData  (laneData),
    .clkLane   (clkLane)
  );
endmodule

// File: tb/dispLinkSer_tb.sv
`timescale 1ns/1ps
module dispLinkSer_tb;
  logic        bitClk = 1'b0;
  logic        pixClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        pdN    = 1'b1;
  logic        strobeSel = 1'b0;
  logic [20:0] pixWord = '0;
  logic [2:0]  laneData;
  logic        clkLane;
  logic        laneOe;

  int checks = 0;
  int errors = 0;
  localparam logic [6:0] PAT = 7'b1100011; // R5: slots 0..6 = 1,1,0,0,0,1,1

  dispLinkSer u_dut (
    .bitClk(bitClk), .pixClk(pixClk), .rstN(rstN), .pdN(pdN),
    .strobeSel(strobeSel), .pixWord(pixWord),
    .laneData(laneData), .clkLane(clkLane), .laneOe(laneOe)
  );

  // 125 MHz bit clock: rising edges at 4 + 8k ns
  always #4 bitClk = ~bitClk;

  // Pixel clock of seven bit periods: rises at 2 + 56m, falls at 30 + 56m
  initial begin
    #2;
    forever begin
      pixClk = 1'b1; #28;
      pixClk = 1'b0; #28;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R1: pack colour and timing fields into their bit positions
  function automatic logic [20:0] mkWord_r1(input logic [5:0] r, input logic [5:0] g,
                                            input logic [5:0] b, input logic hs,
                                            input logic vs, input logic de);
    return {de, vs, hs, b, g, r};
  endfunction

  task automatic testReset_r9();
    #1;
    check("R9 oe in reset", 32'(laneOe), 32'd0);
    check("R9 lanes in reset", 32'({laneData, clkLane}), 32'd0);
  endtask

  // Drives A before the falling edge and B after it; checks one period of slots
  task automatic runWord(input string req, input logic sel,
                         input logic [20:0] a, input logic [20:0] b);
    logic [20:0] w;
    strobeSel = sel;
    w = sel ? b : a;
    @(posedge pixClk); #14 pixWord = a;
    #24 pixWord = b;
    @(posedge pixClk); #14;
    for (int j = 0; j < 7; j++) begin
      check({req, " R2 R6 data slot"}, 32'(laneData), 32'({w[14+j], w[7+j], w[j]}));
      check("R5 clock lane slot", 32'(clkLane), 32'(PAT[j]));
      check("R6 oe during word", 32'(laneOe), 32'd1);
      #8;
    end
  endtask

  task automatic testPowerDown_r7_r8();
    logic [20:0] w;
    w = mkWord_r1(6'h2A, 6'h15, 6'h33, 1'b1, 1'b0, 1'b1);
    pixWord = w;
    @(posedge pixClk); #5 pdN = 1'b0;
    #9;
    check("R7 oe off", 32'(laneOe), 32'd0);
    check("R7 lanes quiet", 32'({laneData, clkLane}), 32'd0);
    @(posedge pixClk); #12 pdN = 1'b1;
    #2;
    check("R8 oe held after release", 32'(laneOe), 32'd0);
    #48;
    check("R8 oe held to boundary", 32'(laneOe), 32'd0);
    check("R8 lanes quiet to boundary", 32'({laneData, clkLane}), 32'd0);
    #8;
    check("R8 oe at boundary", 32'(laneOe), 32'd1);
    check("R8 full word slot 0", 32'({laneData, clkLane}),
          32'({w[14], w[7], w[0], 1'b1}));
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset_r9();
    #100 rstN = 1'b1;      // t = 101, pixel clock low
    #8;                    // t = 109, before the first boundary at 124
    check("R9 oe before first boundary", 32'(laneOe), 32'd0);
    check("R9 lanes before first boundary", 32'({laneData, clkLane}), 32'd0);

    // R3: rising-edge capture sees the late word
    runWord("R3", 1'b1, mkWord_r1(6'h01, 6'h02, 6'h04, 1'b0, 1'b0, 1'b0),
                        mkWord_r1(6'h3F, 6'h00, 6'h2A, 1'b1, 1'b0, 1'b1));
    // R4: falling-edge capture sees the early word
    runWord("R4", 1'b0, mkWord_r1(6'h15, 6'h2A, 6'h0F, 1'b0, 1'b1, 1'b1),
                        mkWord_r1(6'h00, 6'h3F, 6'h00, 1'b1, 1'b1, 1'b0));
    // R1 walking field patterns
    runWord("R1", 1'b1, 21'h0, 21'h1C0000);
    runWord("R1", 1'b0, 21'h155555, 21'h0AAAAA);
    runWord("R2", 1'b1, 21'h0, 21'h1FFFFF);

    testPowerDown_r7_r8();
    runWord("R6", 1'b0, mkWord_r1(6'h07, 6'h38, 6'h21, 1'b0, 1'b1, 1'b0), 21'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule